// File: doc/BRIEF.md
# Readback-Select SPI Register Slave

This block is a 16-bit serial slave with a low-active chip select. SCLK idles low, data is captured on the rising edge and changed on the falling edge. Each accepted frame is decoded into a write to a small bank of 10-bit configuration registers. A register is identified by a bank bit and a 3-bit address. The word shifted out on SO never answers the frame in progress. It carries the register that the most recent read-select command picked. When chip select stays low for more than 16 clocks, SO first sends that register word and then returns the serial input delayed by 16 bits. A host that clocks 32 bits therefore gets its own first word back. In that case the write is taken from the last 16 bits.

The serial pins are sampled in the `clk` domain through a synchronizer. Every visible effect therefore appears three `clk` cycles after the pin change that causes it. Each SCLK level must be held for at least four `clk` cycles. Parity and toggle-bit monitoring are done elsewhere and arrive as the `frame_ok` level. This block samples `frame_ok` when it detects the rising edge of chip select. Frame bits D15 and D14 carry no meaning here.

Top module: `spi_readback_slave`

## Requirements
- R1: After `rst_n` is low at a clock edge, `spi_so` is 0, every field of `cfg_q` is 0 and `rb_sel` is 4'b0001 (bank 0, address 001).
- R2: While chip select is high, `spi_so` is 0.
- R3: The readback word is {2'b00, bank, addr[2:0], payload[9:0]} for the selected register. Its MSB appears on `spi_so` when chip select falls. Each later bit appears on a falling SCLK edge, MSB first. SI is sampled on rising SCLK edges.
- R4: A 16-bit frame is laid out as {D15, D14, bank, addr[2:0], payload[9:0]}. For any address other than 000 and 011, the frame stores the payload in slot {bank, addr} when chip select rises. Slot s occupies `cfg_q[s*10 +: 10]`. Slots whose address is 000 or 011 always read 0.
- R5: A frame to address 000 (in either bank) is a read-select command. It sets `rb_sel` to {frame bank bit, payload[2:0]}. This changes SO from the next frame on and not in the frame that carries the command. Selecting address 000 reads back the payload {6'b0, rb_sel}.
- R6: A write to address 011 changes nothing. A read-select whose payload[2:0] is 011 leaves `rb_sel` unchanged.
- R7: In a 32-bit frame, SO bits 17 to 32 repeat SI bits 1 to 16. Only the last 16 SI bits are decoded.
- R8: A frame is decoded only when its SCLK count is a nonzero multiple of 16. Counts of 0, 15 or 17 leave registers and selection unchanged.
- R9: If `frame_ok` is low when chip select rises, the frame is discarded.
- R10: `regs_clr_n` low at a clock edge restores every register to 0 and `rb_sel` to 4'b0001. The next frame then reads back 16'h0400.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| regs_clr_n | input | 1 | Synchronous active-low restore of registers and selection |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csb | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in, MSB first |
| frame_ok | input | 1 | Frame accepted by the external checks, sampled at chip-select rise |
| spi_so | output | 1 | Serial data out, 0 while deselected |
| cfg_q | output | 160 | Flattened register slots, 10 bits each, indexed by {bank, addr} |
| rb_sel | output | 4 | Current readback selection {bank, addr} |

## Verification
Some properties are checked on every cycle. SO stays quiet while deselected and moves only on a chip-select edge or a falling SCLK. Registers change only on a decoded write or a restore. The selection moves only on a read-select command, and it can never point at the unused address. Other behaviour needs whole frames, and only the bench scenarios show it. These include the one-frame lag between a read-select and its effect on SO, and the echo of the first word in a 32-bit frame. They also include dropped frames of 15 and 17 bits and frames rejected by `frame_ok`. The bench's model follows the pins cycle by cycle and reconstructs complete SO words at the host.

// File: rtl/spi_rb_pkg.sv
// Shared constants, the decoded frame body and readback helpers.
// Assumes a 16-bit frame: two ignored top bits, then the body.
package spi_rb_pkg;
    localparam int FRAME_W   = 16;
    localparam int PAY_W     = 10;
    localparam int ADDR_W    = 3;
    localparam int SLOT_W    = ADDR_W + 1;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int BODY_W    = 1 + ADDR_W + PAY_W;

    localparam logic [ADDR_W-1:0] ADDR_SELECT = 3'b000;
    localparam logic [ADDR_W-1:0] ADDR_UNUSED = 3'b011;

    typedef struct packed {
        logic              bank;
        logic [ADDR_W-1:0] addr;
        logic [PAY_W-1:0]  pay;
    } body_t;

    // Readback word: zero top bits, slot identity, then the payload.
    function automatic logic [FRAME_W-1:0] mk_word(logic [SLOT_W-1:0] slot,
                                                   logic [PAY_W-1:0] pay);
        return {{(FRAME_W-SLOT_W-PAY_W){1'b0}}, slot, pay};
    endfunction

    // A slot holds storage unless its address is the select or unused one.
    function automatic logic slot_writable(int s);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(s);
        return (a != ADDR_SELECT) && (a != ADDR_UNUSED);
    endfunction
endpackage

// File: rtl/spi_rb_sync.sv
// Multi-stage synchronizer for a small bus of asynchronous pins.
// Assumes the pins change slowly against clk (several cycles per level).
module spi_rb_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= d;
            end
        end else begin : g_chain
            // Shift chain: stage 0 captures the pins, the last stage feeds q.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_shift.sv
// Serial engine: detects chip-select and SCLK edges on synchronized pins,
// runs one shift register for both directions, and raises a one-cycle
// write strobe at chip-select rise for frames of a nonzero multiple of 16.
// Assumes mode 0 (SCLK idle low) and that CSB and SCLK never move together.
module spi_rb_shift import spi_rb_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csb_s,
    input  logic               sclk_s,
    input  logic               si_s,
    input  logic               frame_ok,
    input  logic [FRAME_W-1:0] load_word,
    output logic               so,
    output logic               wr_vld,
    output logic [BODY_W-1:0]  wr_body
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic               csb_d, sclk_d;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   bit_lo;
    logic               seen_full;
    logic               so_q;
    logic               csb_fall, csb_rise, sclk_rise, sclk_fall;

    assign csb_fall  =  csb_d & ~csb_s;
    assign csb_rise  = ~csb_d &  csb_s;
    assign sclk_rise = ~csb_s & ~sclk_d &  sclk_s;
    assign sclk_fall = ~csb_s &  sclk_d & ~sclk_s;

    // Edge history of the synchronized pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csb_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csb_d  <= csb_s;
            sclk_d <= sclk_s;
        end
    end

    // Shift register and bit counter: load at select, shift on rising SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr        <= '0;
            bit_lo    <= '0;
            seen_full <= 1'b0;
        end else if (csb_fall) begin
            sr        <= load_word;
            bit_lo    <= '0;
            seen_full <= 1'b0;
        end else if (sclk_rise) begin
            sr     <= {sr[FRAME_W-2:0], si_s};
            bit_lo <= bit_lo + 1'b1;
            if (bit_lo == CNT_W'(FRAME_W-1)) seen_full <= 1'b1;
        end
    end

    // Output bit: first bit at select, next bits on falling SCLK, 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)         so_q <= 1'b0;
        else if (csb_fall)  so_q <= load_word[FRAME_W-1];
        else if (csb_rise)  so_q <= 1'b0;
        else if (sclk_fall) so_q <= sr[FRAME_W-1];
    end

    assign so      = so_q;
    assign wr_vld  = csb_rise & frame_ok & seen_full & (bit_lo == '0);
    assign wr_body = sr[BODY_W-1:0];

    // R2: after a full cycle deselected, SO is low.
    assert_so_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csb_s && csb_d) |-> (so_q == 1'b0));

    // R3: SO only moves on a select edge or a falling SCLK.
    assert_so_moves_on_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(csb_fall || csb_rise || sclk_fall) |=> $stable(so_q));
endmodule

// File: rtl/spi_rb_regs.sv
// Register bank and readback selection. Decodes a committed frame body:
// address 000 is the read-select command, address 011 is unused, all other
// {bank, addr} pairs hold a 10-bit payload. Builds the readback word.
// Assumes wr_vld is a single-cycle strobe with wr_body stable alongside it.
module spi_rb_regs import spi_rb_pkg::*; #(
    parameter logic [SLOT_W-1:0] DEF_SEL = 4'b0001,
    parameter logic [PAY_W-1:0]  REG_DEF = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       regs_clr_n,
    input  logic                       wr_vld,
    input  logic [BODY_W-1:0]          wr_body,
    output logic [NUM_SLOTS*PAY_W-1:0] cfg_q,
    output logic [SLOT_W-1:0]          rb_sel,
    output logic [FRAME_W-1:0]         rb_word
);
    body_t             cmd;
    logic              is_sel;
    logic [SLOT_W-1:0] sel_q;
    logic [PAY_W-1:0]  slot_q [NUM_SLOTS];
    logic [PAY_W-1:0]  rb_pay;

    assign cmd    = body_t'(wr_body);
    assign is_sel = wr_vld && (cmd.addr == ADDR_SELECT);

    // Readback selection: updated by a read-select unless it names 011.
    always_ff @(posedge clk) begin
        if (!rst_n || !regs_clr_n)
            sel_q <= DEF_SEL;
        else if (is_sel && (cmd.pay[ADDR_W-1:0] != ADDR_UNUSED))
            sel_q <= {cmd.bank, cmd.pay[ADDR_W-1:0]};
    end

    // Payload slots: written by a committed frame that names them.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (!rst_n || !regs_clr_n)
                slot_q[s] <= slot_writable(s) ? REG_DEF : '0;
            else if (wr_vld && slot_writable(s) && ({cmd.bank, cmd.addr} == SLOT_W'(s)))
                slot_q[s] <= cmd.pay;
        end
    end

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
            assign cfg_q[g*PAY_W +: PAY_W] = slot_q[g];
        end
    endgenerate

    assign rb_pay  = (sel_q[ADDR_W-1:0] == ADDR_SELECT) ? PAY_W'(sel_q) : slot_q[sel_q];
    assign rb_word = mk_word(sel_q, rb_pay);
    assign rb_sel  = sel_q;

    // R4: registers hold unless a frame commits or a restore is requested.
    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_vld && regs_clr_n) |=> $stable(cfg_q));

    // R5: selection moves only on a read-select command or a restore.
    assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_sel && regs_clr_n) |=> $stable(sel_q));

    // R6: the unused address is never the selection.
    assert_sel_not_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[ADDR_W-1:0] != ADDR_UNUSED);

    // R6: a write to the unused address leaves every slot unchanged.
    assert_unused_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && (cmd.addr == ADDR_UNUSED) && regs_clr_n) |=> $stable(cfg_q));
endmodule

// File: rtl/spi_readback_slave.sv
// Top: synchronizes the serial pins, runs the serial engine and the
// register bank. Outputs trail pin changes by SYNC_STAGES + 1 clk cycles.
// Assumes each SCLK level lasts at least SYNC_STAGES + 2 clk cycles.
module spi_readback_slave import spi_rb_pkg::*; #(
    parameter int                SYNC_STAGES = 2,
    parameter logic [SLOT_W-1:0] DEF_SEL     = 4'b0001
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       regs_clr_n,
    input  logic                       spi_sclk,
    input  logic                       spi_csb,
    input  logic                       spi_si,
    input  logic                       frame_ok,
    output logic                       spi_so,
    output logic [NUM_SLOTS*PAY_W-1:0] cfg_q,
    output logic [SLOT_W-1:0]          rb_sel
);
    logic [2:0]         pins_s;
    logic               wr_vld;
    logic [BODY_W-1:0]  wr_body;
    logic [FRAME_W-1:0] rb_word;

    spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csb, spi_sclk, spi_si}),
        .q     (pins_s)
    );

    spi_rb_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_s     (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .si_s      (pins_s[0]),
        .frame_ok  (frame_ok),
        .load_word (rb_word),
        .so        (spi_so),
        .wr_vld    (wr_vld),
        .wr_body   (wr_body)
    );

    spi_rb_regs #(.DEF_SEL(DEF_SEL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs_clr_n (regs_clr_n),
        .wr_vld     (wr_vld),
        .wr_body    (wr_body),
        .cfg_q      (cfg_q),
        .rb_sel     (rb_sel),
        .rb_word    (rb_word)
    );
endmodule

// File: tb/spi_readback_slave_tb_top.sv
// Bench: a behavioural pin-level model, delayed by the block's three-cycle
// latency and compared on every clock, plus whole-frame checks at the host.
module spi_readback_slave_tb_top;
    localparam int HP  = 4;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_r = 1'b0, clr_r = 1'b1, csb_r = 1'b1, sclk_r = 1'b0, si_r = 1'b0, ok_r = 1'b1;
    logic         so;
    logic [159:0] cfg_q;
    logic [3:0]   rb_sel;

    spi_readback_slave dut_i (
        .clk(clk), .rst_n(rst_r), .regs_clr_n(clr_r), .spi_sclk(sclk_r),
        .spi_csb(csb_r), .spi_si(si_r), .frame_ok(ok_r),
        .spi_so(so), .cfg_q(cfg_q), .rb_sel(rb_sel)
    );

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    // Behavioural model state.
    logic [9:0]   m_reg [16];
    logic [3:0]   m_sel;
    bit           m_q[$];
    int           m_cnt;
    logic [15:0]  m_rx;
    logic         m_so, m_csb, m_sclk;
    logic         h_so  [LAT];
    logic [159:0] h_cfg [LAT];
    logic [3:0]   h_sel [LAT];

    function automatic logic [159:0] m_flat();
        logic [159:0] f;
        for (int s = 0; s < 16; s++) f[s*10 +: 10] = m_reg[s];
        return f;
    endfunction

    function automatic logic [15:0] m_word();
        logic [9:0] p;
        p = (m_sel[2:0] == 3'b000) ? {6'b0, m_sel} : m_reg[m_sel];
        return {2'b00, m_sel, p};
    endfunction

    function automatic void m_fill();
        for (int i = 0; i < LAT; i++) begin
            h_so[i] = m_so; h_cfg[i] = m_flat(); h_sel[i] = m_sel;
        end
    endfunction

    function automatic void m_clear();
        for (int s = 0; s < 16; s++) m_reg[s] = '0;
        m_sel = 4'b0001;
    endfunction

    function automatic void m_apply(logic [15:0] c);
        if (c[12:10] == 3'b000) begin
            if (c[2:0] != 3'b011) m_sel = {c[13], c[2:0]};
        end else if (c[12:10] != 3'b011) begin
            m_reg[c[13:10]] = c[9:0];
        end
    endfunction

    function automatic void m_step();
        logic [15:0] w;
        if (m_csb && !csb_r) begin
            w = m_word();
            m_q.delete();
            for (int i = 15; i >= 0; i--) m_q.push_back(w[i]);
            m_so = w[15]; m_cnt = 0;
        end else if (!m_csb && csb_r) begin
            m_so = 1'b0;
            if (m_cnt > 0 && m_cnt % 16 == 0 && ok_r) m_apply(m_rx);
        end else if (!csb_r && !m_sclk && sclk_r) begin
            m_rx = {m_rx[14:0], si_r};
            void'(m_q.pop_front());
            m_q.push_back(si_r);
            m_cnt++;
        end else if (!csb_r && m_sclk && !sclk_r) begin
            m_so = m_q[0];
        end
        m_csb = csb_r; m_sclk = sclk_r;
        for (int i = LAT-1; i > 0; i--) begin
            h_so[i] = h_so[i-1]; h_cfg[i] = h_cfg[i-1]; h_sel[i] = h_sel[i-1];
        end
        h_so[0] = m_so; h_cfg[0] = m_flat(); h_sel[0] = m_sel;
    endfunction

    task automatic cmp();
        n_cmp++;
        if (so !== h_so[LAT-1] || cfg_q !== h_cfg[LAT-1] || rb_sel !== h_sel[LAT-1]) begin
            n_bad++;
            $display("FAIL %s cycle compare: actual so=%b sel=%h cfg=%h expected so=%b sel=%h cfg=%h",
                     cur_req, so, rb_sel, cfg_q, h_so[LAT-1], h_sel[LAT-1], h_cfg[LAT-1]);
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic c, logic s, logic d);
        @(negedge clk);
        cmp();
        csb_r = c; sclk_r = s; si_r = d;
        m_step();
    endtask

    task automatic hold(int n);
        for (int i = 0; i < n; i++) step(csb_r, sclk_r, si_r);
    endtask

    task automatic clear_pulse();
        @(negedge clk); cmp();
        clr_r = 1'b0; m_clear(); m_fill();
        @(negedge clk); cmp();
        clr_r = 1'b1; m_fill();
        hold(4);
    endtask

    task automatic xfer(logic [31:0] data, int n, logic ok, output logic [31:0] got);
        got = '0;
        ok_r = ok;
        step(1'b0, 1'b0, 1'b0); hold(HP);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, data[n-1-i]); hold(HP);
            got = {got[30:0], so};
            step(1'b0, 1'b1, si_r); hold(HP);
            step(1'b0, 1'b0, si_r); hold(HP);
        end
        step(1'b1, 1'b0, 1'b0); hold(6);
    endtask

    function automatic logic [15:0] cw(logic wd, logic p, logic b, logic [2:0] a, logic [9:0] pay);
        return {wd, p, b, a, pay};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL %s watchdog: actual still running expected finished", cur_req);
        summary();
        $finish;
    end

    initial begin : main
        logic [31:0] got;
        m_so = 1'b0; m_csb = 1'b1; m_sclk = 1'b0; m_cnt = 0; m_rx = '0;
        m_clear(); m_fill();
        cur_req = "R1";
        hold(5);
        rst_r = 1'b1;
        hold(4);
        chk("R1 so", {31'b0, so}, 32'h0);
        chk("R1 cfg", {31'b0, |cfg_q}, 32'h0);
        chk("R1 sel", {28'b0, rb_sel}, 32'h1);

        cur_req = "R4";
        xfer({16'b0, cw(1,1,0,3'b001,10'h155)}, 16, 1'b1, got);
        chk("R3 readback default", got, 32'h0400);
        chk("R4 slot1", {22'b0, cfg_q[10 +: 10]}, 32'h155);
        chk("R2 so idle", {31'b0, so}, 32'h0);
        xfer({16'b0, cw(0,0,1,3'b101,10'h2AA)}, 16, 1'b1, got);
        chk("R3 readback written", got, 32'h0555);
        chk("R4 slot13", {22'b0, cfg_q[130 +: 10]}, 32'h2AA);

        cur_req = "R5";
        xfer({16'b0, cw(1,0,1,3'b000,10'h005)}, 16, 1'b1, got);
        chk("R5 select frame keeps old word", got, 32'h0555);
        chk("R5 sel", {28'b0, rb_sel}, 32'hD);
        xfer({16'b0, cw(0,1,0,3'b010,10'h3C3)}, 16, 1'b1, got);
        chk("R5 next frame shows selection", got, 32'h36AA);
        chk("R4 slot2", {22'b0, cfg_q[20 +: 10]}, 32'h3C3);

        cur_req = "R6";
        xfer({16'b0, cw(0,0,0,3'b000,10'h003)}, 16, 1'b1, got);
        chk("R6 select 011 ignored", {28'b0, rb_sel}, 32'hD);
        xfer({16'b0, cw(0,0,0,3'b011,10'h3FF)}, 16, 1'b1, got);
        chk("R6 readback unchanged", got, 32'h36AA);
        chk("R6 slot3", {22'b0, cfg_q[30 +: 10]}, 32'h0);

        cur_req = "R7";
        xfer({cw(0,0,0,3'b110,10'h111), cw(0,0,0,3'b100,10'h0F0)}, 32, 1'b1, got);
        chk("R7 echo", got, 32'h36AA_1911);
        chk("R7 slot4 from last word", {22'b0, cfg_q[40 +: 10]}, 32'h0F0);
        chk("R7 slot6 first word ignored", {22'b0, cfg_q[60 +: 10]}, 32'h0);

        cur_req = "R8";
        xfer({17'b0, 15'h1C77}, 15, 1'b1, got);
        chk("R8 15 bits so", got, 32'h1B55);
        chk("R8 15 bits dropped", {22'b0, cfg_q[70 +: 10]}, 32'h0);
        xfer({15'b0, 1'b1, 16'h1C77}, 17, 1'b1, got);
        chk("R8 17 bits so", got, 32'h6D55);
        chk("R8 17 bits dropped", {22'b0, cfg_q[70 +: 10]}, 32'h0);
        xfer(32'h0, 0, 1'b1, got);
        chk("R8 empty frame", {28'b0, rb_sel}, 32'hD);

        cur_req = "R9";
        xfer({16'b0, 16'h1C77}, 16, 1'b0, got);
        chk("R9 rejected", {22'b0, cfg_q[70 +: 10]}, 32'h0);
        xfer({16'b0, 16'h1C77}, 16, 1'b1, got);
        chk("R9 accepted", {22'b0, cfg_q[70 +: 10]}, 32'h077);

        cur_req = "R5";
        xfer({16'b0, cw(0,0,1,3'b000,10'h000)}, 16, 1'b1, got);
        xfer({16'b0, cw(0,0,0,3'b001,10'h0AB)}, 16, 1'b1, got);
        chk("R5 select slot reads selection", got, 32'h2008);

        cur_req = "R10";
        clear_pulse();
        chk("R10 cfg cleared", {31'b0, |cfg_q}, 32'h0);
        chk("R10 sel default", {28'b0, rb_sel}, 32'h1);
        xfer({16'b0, cw(0,0,0,3'b000,10'h001)}, 16, 1'b1, got);
        chk("R10 readback after clear", got, 32'h0400);

        hold(4);
        summary();
        $finish;
    end
endmodule